// File: doc/BRIEF.md
# Latched Six-Decade BCD Counter

This block is a decimal event counter built from cascaded BCD decades. It advances by one on every clock cycle in which the count-enable input is high. That enable is a pulse train derived from the reference oscillator, for example a 4 MHz crystal divided by two, giving 2 MHz counting. The counter keeps running until a clear strobe zeroes every decade.

A transfer strobe copies the whole running count into a bank of 4-bit holding registers in a single cycle. The counter keeps running after the copy. A display scanner then reads the held snapshot one digit at a time, starting at the least significant digit. It steps an index that wraps around after the most significant digit, and a restart input returns the index to zero.

Two tap flags come from the decades chosen by parameter (by default the fourth and fifth). They give downstream timing logic a coarse view of the running count. Each flag is high while its decade does not read 9.

Top module: `bcd_snapshot_counter`

## Requirements
- R1: While reset is asserted, every decade, every holding register and the scan index are zero. After reset, the scanned digit reads 0 and both tap flags are high.
- R2: In a cycle with count_en high and clear low, the least significant decade advances by one, and from 9 it goes to 0.
- R3: A decade above the least significant one advances only in a cycle where count_en is high and every lower decade reads 9. The whole count therefore wraps from all nines to all zeros.
- R4: A clear strobe zeroes all decades at the next clock edge, whatever the state of count_en.
- R5: The holding registers change only on a transfer strobe. A clear, counting or scanning leaves them unchanged.
- R6: A transfer strobe loads each holding register with the value its decade held before that edge. When clear and transfer coincide, the pre-clear count is captured.
- R7: Each scan_step advances scan_idx by one, and the step from NUM_DIGITS-1 goes to 0.
- R8: scan_restart forces scan_idx to 0 at the next edge and takes priority over scan_step.
- R9: scan_digit shows the holding register selected by scan_idx without delay. Index 0 is the least significant digit.
- R10: tap_lo_flag is high exactly when decade TAP_LO does not read 9. tap_hi_flag does the same for decade TAP_HI.
- R11: With count_en low and clear low, no decade changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_en | input | 1 | One-cycle count pulse from the divided reference clock |
| clear | input | 1 | Zeroes all decades |
| xfer | input | 1 | Copies the running count into the holding registers |
| scan_step | input | 1 | Advances the readout index |
| scan_restart | input | 1 | Returns the readout index to 0 |
| scan_digit | output | 4 | BCD digit held at the current index |
| scan_idx | output | $clog2(NUM_DIGITS) | Current readout index, 0 for the least significant digit |
| tap_lo_flag | output | 1 | High while decade TAP_LO is not 9 |
| tap_hi_flag | output | 1 | High while decade TAP_HI is not 9 |

## Verification
The bench builds the counter with NUM_DIGITS=4, TAP_LO=2 and TAP_HI=3. A full wrap from 9999 to 0000 then takes ten thousand enabled cycles, which makes the carry into the top decade and both tap flags reachable within the run. Random stretches of enables, clears, transfers and scan moves are compared every cycle against a bench model that keeps the count as an integer. Directed cases cover clear together with transfer, a clear without transfer, index wrap, restart together with step, and the all-nines rollover.

// File: rtl/bcd_snap_pkg.sv
package bcd_snap_pkg;
   localparam int BCD_W = 4;
   typedef logic [BCD_W-1:0] bcd_t;
   localparam bcd_t BCD_TOP = 4'd9;

   function automatic bcd_t bcd_inc(input bcd_t d);
      return (d == BCD_TOP) ? '0 : bcd_t'(d + 4'd1);
   endfunction
endpackage

// File: rtl/bcd_decade.sv
module bcd_decade
   import bcd_snap_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en_in,
   output bcd_t digit,
   output logic carry_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      digit <= '0;
      else if (clr)    digit <= '0;
      else if (en_in)  digit <= bcd_inc(digit);
   end

   assign carry_out = en_in & (digit == BCD_TOP);

   // R2 / R3: an enabled decade steps by one and wraps after 9
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && en_in) |=> digit == (($past(digit) == BCD_TOP) ? 4'd0 : $past(digit) + 4'd1));
   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !en_in) |=> $stable(digit));
   a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> digit == 4'd0);
   a_r2_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
      digit <= BCD_TOP);
endmodule

// File: rtl/bcd_hold_bank.sv
module bcd_hold_bank
   import bcd_snap_pkg::*;
#(
   parameter int NUM_DIGITS = 6,
   localparam int FLAT_W = NUM_DIGITS * BCD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [FLAT_W-1:0] src,
   output logic [FLAT_W-1:0] held
);
   for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     held[g*BCD_W +: BCD_W] <= '0;
         else if (load)  held[g*BCD_W +: BCD_W] <= src[g*BCD_W +: BCD_W];
      end
   end

   a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(held));
   a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> held == $past(src));
endmodule

// File: rtl/bcd_scan_mux.sv
module bcd_scan_mux
   import bcd_snap_pkg::*;
#(
   parameter int NUM_DIGITS = 6,
   localparam int IDX_W  = $clog2(NUM_DIGITS),
   localparam int FLAT_W = NUM_DIGITS * BCD_W,
   localparam int LAST   = NUM_DIGITS - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              restart,
   input  logic [FLAT_W-1:0] held,
   output logic [IDX_W-1:0]  idx,
   output bcd_t              digit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           idx <= '0;
      else if (restart)                     idx <= '0;
      else if (step && idx == IDX_W'(LAST)) idx <= '0;
      else if (step)                        idx <= idx + 1'b1;
   end

   always_comb begin
      digit = '0;
      for (int i = 0; i < NUM_DIGITS; i++)
         if (idx == IDX_W'(i)) digit = held[i*BCD_W +: BCD_W];
   end

   a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> idx == '0);
   a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !restart && idx == IDX_W'(LAST)) |=> idx == '0);
   a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !restart && idx != IDX_W'(LAST)) |=> idx == $past(idx) + 1'b1);
   a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !restart) |=> $stable(idx));
   a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= IDX_W'(LAST));
endmodule

// File: rtl/bcd_snapshot_counter.sv
module bcd_snapshot_counter
   import bcd_snap_pkg::*;
#(
   parameter int NUM_DIGITS = 6,
   parameter int TAP_LO     = 3,
   parameter int TAP_HI     = 4,
   localparam int IDX_W     = $clog2(NUM_DIGITS),
   localparam int FLAT_W    = NUM_DIGITS * BCD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             count_en,
   input  logic             clear,
   input  logic             xfer,
   input  logic             scan_step,
   input  logic             scan_restart,
   output logic [3:0]       scan_digit,
   output logic [IDX_W-1:0] scan_idx,
   output logic             tap_lo_flag,
   output logic             tap_hi_flag
);
   if (NUM_DIGITS < 2) begin : g_bad_digits
      $error("NUM_DIGITS must be at least 2");
   end
   if (TAP_LO < 0 || TAP_LO >= TAP_HI || TAP_HI >= NUM_DIGITS) begin : g_bad_taps
      $error("taps need 0 <= TAP_LO < TAP_HI < NUM_DIGITS");
   end

   logic [NUM_DIGITS:0]  chain;
   logic [FLAT_W-1:0]    run_flat;
   logic [FLAT_W-1:0]    held_flat;

   assign chain[0] = count_en;

   for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dec
      bcd_t d;
      bcd_decade u_dec (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (clear),
         .en_in    (chain[g]),
         .digit    (d),
         .carry_out(chain[g+1])
      );
      assign run_flat[g*BCD_W +: BCD_W] = d;
   end

   bcd_hold_bank #(.NUM_DIGITS(NUM_DIGITS)) u_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .load (xfer),
      .src  (run_flat),
      .held (held_flat)
   );

   bcd_scan_mux #(.NUM_DIGITS(NUM_DIGITS)) u_scan (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (scan_step),
      .restart(scan_restart),
      .held   (held_flat),
      .idx    (scan_idx),
      .digit  (scan_digit)
   );

   assign tap_lo_flag = run_flat[TAP_LO*BCD_W +: BCD_W] != BCD_TOP;
   assign tap_hi_flag = run_flat[TAP_HI*BCD_W +: BCD_W] != BCD_TOP;

   // R6: coincident clear and transfer captures the pre-clear count
   a_r6_clear_xfer: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && xfer) |=> held_flat == $past(run_flat));
   // R4: after a clear, the whole chain reads zero
   a_r4_all_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> run_flat == '0);
   // R3: top decade moves only when the full carry chain fired
   a_r3_top_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !chain[NUM_DIGITS-1]) |=> $stable(run_flat[FLAT_W-1 -: BCD_W]));
   // R10: lo flag drops only on a count or clear edge
   a_r10_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !count_en) |=> $stable(tap_lo_flag) && $stable(tap_hi_flag));
endmodule

// File: tb/bcd_snapshot_counter_bench.sv
`timescale 1ns/1ps
module bcd_snapshot_counter_bench;
   localparam int N      = 4;
   localparam int TLO    = 2;
   localparam int THI    = 3;
   localparam int IDX_W  = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic count_en = 0, clear = 0, xfer = 0, scan_step = 0, scan_restart = 0;
   logic [3:0]       scan_digit;
   logic [IDX_W-1:0] scan_idx;
   logic tap_lo_flag, tap_hi_flag;

   always #2.5 clk = ~clk;

   bcd_snapshot_counter #(.NUM_DIGITS(N), .TAP_LO(TLO), .TAP_HI(THI)) u_bcd_snapshot_counter (
      .clk(clk), .rst_n(rst_n), .count_en(count_en), .clear(clear), .xfer(xfer),
      .scan_step(scan_step), .scan_restart(scan_restart), .scan_digit(scan_digit),
      .scan_idx(scan_idx), .tap_lo_flag(tap_lo_flag), .tap_hi_flag(tap_hi_flag));

   int checks = 0, errors = 0;
   int cnt = 0, idx = 0;
   int hold [N];
   bit done = 0;

   function automatic int modulus();
      int m = 1;
      for (int i = 0; i < N; i++) m = m * 10;
      return m;
   endfunction

   function automatic int dig(int v, int k);
      int x = v;
      for (int i = 0; i < k; i++) x = x / 10;
      return x % 10;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(bit en, bit clr, bit xf, bit st, bit rs);
      count_en = en; clear = clr; xfer = xf; scan_step = st; scan_restart = rs;
      if (xf) for (int i = 0; i < N; i++) hold[i] = dig(cnt, i);
      if (clr) cnt = 0;
      else if (en) cnt = (cnt + 1) % modulus();
      if (rs) idx = 0;
      else if (st) idx = (idx == N-1) ? 0 : idx + 1;
      @(posedge clk);
      @(negedge clk);
      check("R7 scan index", int'(scan_idx), idx);
      check("R9 scan digit", int'(scan_digit), hold[idx]);
      check("R10 tap lo", int'(tap_lo_flag), int'(dig(cnt, TLO) != 9));
      check("R10 tap hi", int'(tap_hi_flag), int'(dig(cnt, THI) != 9));
   endtask

   task automatic read_held(string req, int v);
      cyc(0, 0, 0, 0, 1);
      for (int k = 0; k < N; k++) begin
         check(req, int'(scan_digit), dig(v, k));
         cyc(0, 0, 0, 1, 0);
      end
   endtask

   task automatic verify_count(string req, int v);
      cyc(0, 0, 1, 0, 1);
      for (int k = 0; k < N; k++) begin
         check(req, int'(scan_digit), dig(v, k));
         cyc(0, 0, 0, 1, 0);
      end
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < N; i++) hold[i] = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 idx", int'(scan_idx), 0);
      check("R1 digit", int'(scan_digit), 0);
      check("R1 flags", int'({tap_lo_flag, tap_hi_flag}), 3);
      rst_n = 1'b1;
      @(negedge clk);

      repeat (7) cyc(1, 0, 0, 0, 0);
      verify_count("R2 count", 7);
      repeat (5) cyc(0, 0, 0, 0, 0);
      verify_count("R11 idle hold", 7);
      cyc(1, 1, 0, 0, 0);
      verify_count("R4 clear with enable", 0);

      repeat (23) cyc(1, 0, 0, 0, 0);
      cyc(1, 1, 1, 0, 0);
      read_held("R6 clear plus transfer", 23);
      cyc(0, 1, 0, 0, 0);
      read_held("R5 hold after clear", 23);
      verify_count("R4 zero after clear", 0);

      repeat (9999) cyc(1, 0, 0, 0, 0);
      verify_count("R3 all nines", 9999);
      cyc(1, 0, 0, 0, 0);
      verify_count("R3 rollover", 0);

      cyc(0, 0, 0, 0, 1);
      repeat (N) cyc(0, 0, 0, 1, 0);
      check("R7 wrap", int'(scan_idx), 0);
      cyc(0, 0, 0, 1, 0);
      cyc(0, 0, 0, 1, 1);
      check("R8 restart over step", int'(scan_idx), 0);

      for (int t = 0; t < 6000; t++) begin
         cyc(($urandom % 4) != 0, ($urandom % 500) == 0, ($urandom % 40) == 0,
             ($urandom % 3) == 0, ($urandom % 60) == 0);
      end
      verify_count("R2 random count", cnt);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule